// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Address-Space Tags

This block translates 32-bit virtual addresses of a RISC core into physical addresses. Translations come from a small fully associative table of 4 KiB page mappings. Each mapping is tagged with a short address-space identifier, so switching processes only means loading a new current identifier; the table needs flushing only after every identifier has been handed out. A window of kernel address space is mapped directly and never consults the table.

The block has no table walker. When a lookup fails, the block records a ready-made refill context and raises one of several exception codes:

- the translation-register high word, holding the faulting page number and the current identifier;
- the return PC, corrected when the faulting instruction sits in a branch delay slot;
- a pointer to the page-table word for the faulting page.

A short trap routine then reads that pointer, loads one word into the low translation register and issues a write command. The write goes either to an explicitly indexed slot or to a slot picked by a free-running replacement counter that skips a protected (wired) low range. A probe command looks up the high-word tag and reports the slot that holds it.

Top module: `sw_tlb`

## Requirements
- R1: After reset, Index reads 0, Wired reads 0, Random reads ENTRIES-1 (63), Cause reads 0 and EntryHi reads 0.
- R2: A mapped lookup hits an entry only when the page number (vaddr[31:12]) equals the entry's page number and either the entry's identifier equals the current identifier (EntryHi[5:0]) or the entry's global bit is set.
- R3: Addresses 0x8000_0000 to 0xBFFF_FFFF never miss. They translate to the address with bits [31:29] cleared and are reported uncached when vaddr[29] is 1.
- R4: A lookup with no matching entry raises code 3 when vaddr[31] is 0 (user space) and code 4 for kernel-mapped space (0xC000_0000 and up).
- R5: On any exception (codes 1 to 4), EntryHi is loaded one cycle later with the faulting page number in bits [31:12] and the current identifier in bits [5:0].
- R6: On any exception, EPC becomes lk_pc, or lk_pc-4 when lk_in_delay is set. Cause becomes {bd, 28'b0, code[2:0]}, with bd in bit 31 equal to lk_in_delay.
- R7: The PTE pointer register reads as the written base (bits [31:2]) plus four times the page number of the last exception.
- R8: cmd_write_index copies EntryHi and EntryLo into the slot given by Index[5:0]. EntryLo holds the frame number in [31:12], the uncached flag in bit 3, the dirty flag in bit 2, the valid flag in bit 1 and the global flag in bit 0.
- R9: A matching entry whose valid flag is clear raises code 2 (invalid), not a refill code.
- R10: A store through a valid matching entry whose dirty flag is clear raises code 1 (modify), while a load through the same entry translates normally.
- R11: Random counts down once per cycle from ENTRIES-1 to Wired and then wraps to ENTRIES-1. Writing Wired sets Random to ENTRIES-1. cmd_write_random writes the slot that Random shows in that cycle.
- R12: cmd_probe sets Index to the lowest matching slot for the EntryHi tag with bit 31 clear, or to 0x8000_0000 when no slot matches.
- R13: Translation, hit, code and uncached outputs are combinational in the lookup cycle. A mapped hit returns {frame, vaddr[11:0]} and reports uncached from the entry's uncached flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Access is a store |
| lk_pc | input | 32 | PC of the accessing instruction |
| lk_in_delay | input | 1 | Accessing instruction sits in a branch delay slot |
| lk_paddr | output | 32 | Physical address |
| lk_hit | output | 1 | Translation succeeded without exception |
| lk_uncached | output | 1 | Access bypasses caches (valid with lk_hit) |
| lk_code | output | 3 | Exception code: 0 none, 1 modify, 2 invalid, 3 user refill, 4 kernel refill |
| reg_sel | input | 3 | Register: 0 Index, 1 Random, 2 Wired, 3 EntryHi, 4 EntryLo, 5 PTE pointer, 6 Cause, 7 EPC |
| reg_wr | input | 1 | Write the selected register (Index, Wired, EntryHi, EntryLo, PTE base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| cmd_write_index | input | 1 | Write EntryHi/EntryLo to slot Index |
| cmd_write_random | input | 1 | Write EntryHi/EntryLo to slot Random |
| cmd_probe | input | 1 | Search for the EntryHi tag and update Index |

## Verification
Lookups are driven in several patterns. Direct-window addresses show that the table is bypassed. Unmatched user and kernel-mapped addresses tell the two refill codes apart. A tag with the wrong identifier is compared with a global entry reached under a foreign identifier, which separates identifier matching from the global override. Entries with the valid flag clear or the dirty flag clear separate the invalid and modify exceptions from refill, and the modify case is tried with both a load and a store. The latched EntryHi, EPC (with and without a delay slot) and PTE pointer are read back through the register port after each exception. The replacement counter is followed cycle by cycle against Wired, and the slot it picked is confirmed through a probe.

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_store,
  input  logic [31:0] lk_pc,
  input  logic        lk_in_delay,
  output logic [31:0] lk_paddr,
  output logic        lk_hit,
  output logic        lk_uncached,
  output logic [2:0]  lk_code,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cmd_write_index,
  input  logic        cmd_write_random,
  input  logic        cmd_probe
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = 20;
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [2:0] C_NONE = 3'd0, C_MOD = 3'd1, C_INV = 3'd2,
                         C_UREF = 3'd3, C_KREF = 3'd4;

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [VPN_W-1:0]  e_pfn  [ENTRIES];
  logic              e_g [ENTRIES], e_v [ENTRIES], e_d [ENTRIES], e_n [ENTRIES];

  logic [IDX_W-1:0]  idx_q, rnd_q, wired_q;
  logic              fail_q;
  logic [VPN_W-1:0]  hi_vpn, lo_pfn, bad_vpn;
  logic [ASID_W-1:0] hi_asid;
  logic              lo_n, lo_d, lo_v, lo_g;
  logic [31:2]       ptb_q;
  logic [31:0]       epc_q;
  logic [2:0]        code_q;
  logic              bd_q;

  function automatic logic [IDX_W:0] find(input logic [VPN_W-1:0] vpn,
                                          input logic [ASID_W-1:0] asid);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (e_vpn[i] == vpn && (e_g[i] || e_asid[i] == asid))
        r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  logic [IDX_W:0]   lk_m, pr_m;
  logic [IDX_W-1:0] ls;
  logic             direct, exc;

  assign direct = lk_vaddr[31:30] == 2'b10;
  assign lk_m   = find(lk_vaddr[31:12], hi_asid);
  assign pr_m   = find(hi_vpn, hi_asid);
  assign ls     = lk_m[IDX_W-1:0];

  always_comb begin
    if (!lk_valid || direct)          lk_code = C_NONE;
    else if (!lk_m[IDX_W])            lk_code = lk_vaddr[31] ? C_KREF : C_UREF;
    else if (!e_v[ls])                lk_code = C_INV;
    else if (lk_store && !e_d[ls])    lk_code = C_MOD;
    else                              lk_code = C_NONE;
  end

  assign exc         = lk_code != C_NONE;
  assign lk_hit      = lk_valid && !exc;
  assign lk_paddr    = direct ? {3'b000, lk_vaddr[28:0]} : {e_pfn[ls], lk_vaddr[11:0]};
  assign lk_uncached = lk_hit && (direct ? lk_vaddr[29] : e_n[ls]);

  logic             wr_en;
  logic [IDX_W-1:0] wr_slot;
  assign wr_en   = cmd_write_index || cmd_write_random;
  assign wr_slot = cmd_write_index ? idx_q : rnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0; e_asid[i] <= '0; e_pfn[i] <= '0;
        e_g[i] <= 1'b0; e_v[i] <= 1'b0; e_d[i] <= 1'b0; e_n[i] <= 1'b0;
      end
    end else if (wr_en) begin
      e_vpn[wr_slot]  <= hi_vpn;
      e_asid[wr_slot] <= hi_asid;
      e_pfn[wr_slot]  <= lo_pfn;
      e_g[wr_slot] <= lo_g; e_v[wr_slot] <= lo_v;
      e_d[wr_slot] <= lo_d; e_n[wr_slot] <= lo_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; fail_q <= 1'b0; rnd_q <= TOP; wired_q <= '0;
      hi_vpn <= '0; hi_asid <= '0;
      lo_pfn <= '0; {lo_n, lo_d, lo_v, lo_g} <= 4'b0;
      ptb_q <= '0; bad_vpn <= '0; epc_q <= '0; code_q <= C_NONE; bd_q <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 3'd2) rnd_q <= TOP;
      else if (rnd_q <= wired_q)      rnd_q <= TOP;
      else                            rnd_q <= rnd_q - 1'b1;

      if (reg_wr && reg_sel == 3'd2) wired_q <= reg_wdata[IDX_W-1:0];
      if (reg_wr && reg_sel == 3'd4) begin
        lo_pfn <= reg_wdata[31:12];
        {lo_n, lo_d, lo_v, lo_g} <= reg_wdata[3:0];
      end
      if (reg_wr && reg_sel == 3'd5) ptb_q <= reg_wdata[31:2];

      if (cmd_probe) begin
        fail_q <= !pr_m[IDX_W];
        idx_q  <= pr_m[IDX_W] ? pr_m[IDX_W-1:0] : '0;
      end else if (reg_wr && reg_sel == 3'd0) begin
        fail_q <= 1'b0;
        idx_q  <= reg_wdata[IDX_W-1:0];
      end

      if (exc) begin
        hi_vpn  <= lk_vaddr[31:12];
        bad_vpn <= lk_vaddr[31:12];
        epc_q   <= lk_in_delay ? lk_pc - 32'd4 : lk_pc;
        bd_q    <= lk_in_delay;
        code_q  <= lk_code;
      end else if (reg_wr && reg_sel == 3'd3) begin
        hi_vpn  <= reg_wdata[31:12];
        hi_asid <= reg_wdata[ASID_W-1:0];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = {fail_q, {(31 - IDX_W){1'b0}}, idx_q};
      3'd1: reg_rdata = {{(32 - IDX_W){1'b0}}, rnd_q};
      3'd2: reg_rdata = {{(32 - IDX_W){1'b0}}, wired_q};
      3'd3: reg_rdata = {hi_vpn, {(12 - ASID_W){1'b0}}, hi_asid};
      3'd4: reg_rdata = {lo_pfn, 8'h00, lo_n, lo_d, lo_v, lo_g};
      3'd5: reg_rdata = {ptb_q, 2'b00} + {10'b0, bad_vpn, 2'b00};
      3'd6: reg_rdata = {bd_q, 28'b0, code_q};
      default: reg_rdata = epc_q;
    endcase
  end

  a_r3_direct_never_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_vaddr[31:30] == 2'b10) |-> (lk_hit && lk_paddr[31:29] == 3'b000));

  a_r4_user_not_kernel_code: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_vaddr[31]) |-> (lk_code != C_KREF));

  a_r5_hi_captures_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_code != C_NONE) |=> (hi_vpn == $past(lk_vaddr[31:12]) && $stable(hi_asid)));

  a_r6_delay_slot_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_code != C_NONE && lk_in_delay) |=> (epc_q == $past(lk_pc) - 32'd4 && bd_q));

  a_r11_random_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q >= wired_q);

  a_r12_probe_hit_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_probe && !wr_en) |=> (fail_q || e_vpn[idx_q] == $past(hi_vpn)));
endmodule

// File: tb/sim_sw_tlb.sv
module sim_sw_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_store, lk_in_delay;
  logic [31:0] lk_vaddr, lk_pc;
  logic [31:0] lk_paddr;
  logic        lk_hit, lk_uncached;
  logic [2:0]  lk_code;
  logic [2:0]  reg_sel;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_write_index, cmd_write_random, cmd_probe;

  always #10 clk = ~clk;

  sw_tlb u0 (.*);

  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];
  int          rnd_m, wired_m, wired_new, slot_r;
  bit          wired_pend;

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    kq.push_back(kind); eq.push_back(exp); tq.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (kq.size() > 0) begin
        int k;
        logic [31:0] e, a;
        string t;
        k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
        case (k)
          0: a = lk_paddr;
          1: a = {31'b0, lk_hit};
          2: a = {29'b0, lk_code};
          3: a = {31'b0, lk_uncached};
          default: a = reg_rdata;
        endcase
        n_run++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    if (wired_pend) begin
      wired_m = wired_new; rnd_m = 63; wired_pend = 1'b0;
    end else begin
      rnd_m = (rnd_m <= wired_m) ? 63 : rnd_m - 1;
    end
    @(negedge clk);
    lk_valid = 0; reg_wr = 0; cmd_write_index = 0; cmd_write_random = 0; cmd_probe = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    if (sel == 3'd2) begin wired_pend = 1'b1; wired_new = int'(d[5:0]); end
    step();
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] e, input string tag);
    reg_sel = sel; chk(4, e, tag); step();
  endtask

  task automatic lk(input logic [31:0] va, input logic st, input logic [31:0] pc, input logic bd);
    lk_valid = 1; lk_vaddr = va; lk_store = st; lk_pc = pc; lk_in_delay = bd;
  endtask

  task automatic put(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] idx);
    wr(3, hi); wr(4, lo); wr(0, idx);
    cmd_write_index = 1; step();
  endtask

  task automatic probe(input logic [31:0] hi);
    wr(3, hi); cmd_probe = 1; step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_vaddr = 0; lk_store = 0; lk_pc = 0; lk_in_delay = 0;
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    cmd_write_index = 0; cmd_write_random = 0; cmd_probe = 0;
    wired_pend = 0; rnd_m = 63; wired_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    rd(1, 32'd63, "R1 random");
    rd(0, 32'd0, "R1 index");
    rd(2, 32'd0, "R1 wired");
    rd(6, 32'd0, "R1 cause");
    rd(3, 32'd0, "R1 entryhi");

    lk(32'h8001_2344, 0, 0, 0);
    chk(0, 32'h0001_2344, "R3 paddr"); chk(1, 1, "R3 hit"); chk(3, 0, "R3 cached");
    step();
    lk(32'hA040_0010, 1, 0, 0);
    chk(0, 32'h0040_0010, "R3 paddr"); chk(3, 1, "R3 uncached"); chk(2, 0, "R3 code");
    step();

    wr(3, 32'h0000_0005);
    lk(32'h0040_3abc, 0, 32'h1000, 0);
    chk(2, 3, "R4 user refill"); chk(1, 0, "R4 no hit");
    step();
    rd(3, 32'h0040_3005, "R5 entryhi");
    rd(6, 32'h0000_0003, "R6 cause");
    rd(7, 32'h0000_1000, "R6 epc");
    wr(5, 32'hC000_0000);
    rd(5, 32'hC000_100C, "R7 pte ptr");

    lk(32'hC000_5000, 0, 32'h2008, 1);
    chk(2, 4, "R4 kernel refill");
    step();
    rd(7, 32'h0000_2004, "R6 epc delay");
    rd(6, 32'h8000_0004, "R6 cause bd");
    rd(3, 32'hC000_5005, "R5 entryhi kernel");
    rd(5, 32'hC030_0014, "R7 pte ptr kernel");

    put(32'h0040_3005, 32'h1234_5006, 10);
    lk(32'h0040_3abc, 0, 0, 0);
    chk(0, 32'h1234_5abc, "R8 paddr"); chk(1, 1, "R8 hit");
    step();
    lk(32'h0040_3abc, 1, 0, 0);
    chk(2, 0, "R10 store dirty ok"); chk(0, 32'h1234_5abc, "R13 paddr");
    step();

    wr(3, 32'h0000_0006);
    lk(32'h0040_3abc, 0, 0, 0);
    chk(2, 3, "R2 asid mismatch");
    step();

    put(32'h0077_7001, 32'h00ab_c003, 20);
    wr(3, 32'h0000_0002);
    lk(32'h0077_7010, 0, 0, 0);
    chk(0, 32'h00ab_c010, "R2 global paddr"); chk(1, 1, "R2 global hit");
    step();

    put(32'h0050_0002, 32'h5555_5004, 30);
    lk(32'h0050_0000, 0, 0, 0);
    chk(2, 2, "R9 invalid");
    step();
    rd(3, 32'h0050_0002, "R5 entryhi invalid");

    put(32'h0060_0002, 32'h6666_6002, 11);
    lk(32'h0060_0123, 1, 0, 0);
    chk(2, 1, "R10 modify");
    step();
    lk(32'h0060_0123, 0, 0, 0);
    chk(0, 32'h6666_6123, "R10 load paddr"); chk(3, 0, "R13 cached");
    step();

    put(32'h0060_1002, 32'h6666_700A, 12);
    lk(32'h0060_1fff, 0, 0, 0);
    chk(0, 32'h6666_7fff, "R13 paddr"); chk(3, 1, "R13 uncached"); chk(1, 1, "R13 hit");
    step();

    probe(32'h0060_0002);
    rd(0, 32'd11, "R12 probe hit");
    probe(32'h0099_9002);
    rd(0, 32'h8000_0000, "R12 probe miss");
    probe(32'h0077_7005);
    rd(0, 32'd20, "R12 probe global");

    wr(2, 32'd60);
    for (int i = 0; i < 5; i++) rd(1, rnd_m, "R11 random");
    rd(2, 32'd60, "R11 wired");
    wr(3, 32'h0088_8002);
    wr(4, 32'h0888_8002);
    slot_r = rnd_m;
    cmd_write_random = 1; step();
    cmd_probe = 1; step();
    rd(0, slot_r, "R11 random slot");
    lk(32'h0088_8044, 0, 0, 0);
    chk(0, 32'h0888_8044, "R11 random entry");
    step();
    rd(0, (slot_r >= 60) ? slot_r : 32'hFFFF_FFFF, "R11 slot above wired");

    step(); step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule